// File: doc/BRIEF.md
# Pulse-Per-Second Disciplined Timebase with Timed Trigger

This block keeps local time as a seconds count and a subsecond tick count. It is steered by an external once-per-second pulse. The pulse carries only phase and no time of day. On every synchronized rising edge of the pulse, the subsecond count is snapped back to zero. The seconds count advances by one on the snap, or on its own natural rollover. The seconds value itself is written separately through a load input.

A lock monitor measures the interval between pulse edges. It marks an edge that lands well away from the expected rollover as a phase error. It drops the lock flag when an edge arrives out of place, or when no edge comes within one second plus a tolerance. Without edges the counter keeps running on the local clock.

Two outputs are derived from local time. The first is a regenerated pulse of programmable width that starts at every second boundary. The second is a one-shot trigger that fires when local time reaches a programmed future instant. Several nodes programmed with the same instant act together.

Top module: `ppsd_timebase`

## Requirements
- R1: While reset is high, and on the first cycle after it, now_sec and now_sub are 0 and locked, phase_err and fire are 0.
- R2: Without pulse edges, now_sub steps by one per clock from 0 to TICKS_PER_SEC-1 and then wraps to 0. On each wrap now_sec increases by one.
- R3: A rising edge of pps_in first sampled at clock edge k passes through a two-flop synchronizer. now_sub reads 0 after clock edge k+2.
- R4: At the snap, now_sec increases by one if the pre-snap subsecond value is at least TOLERANCE. It stays unchanged if that value is below TOLERANCE, because a late edge arrives after the natural wrap has already counted the second.
- R5: A snap whose pre-snap value lies in [TOLERANCE, TICKS_PER_SEC-2-TOLERANCE] pulses phase_err for exactly one cycle and clears locked on that same edge.
- R6: A snap whose pre-snap value is below TOLERANCE, or at least TICKS_PER_SEC-1-TOLERANCE, sets locked.
- R7: If TICKS_PER_SEC+TOLERANCE clock edges pass after a snap with no further edge, locked clears on the last of them. The counter keeps free-running.
- R8: sec_load_en loads sec_load_val into now_sec on the next clock edge. The load takes priority over any increment, including one on a wrap in the same cycle. now_sub is unaffected.
- R9: pps_out is high while now_sub is below the effective width. The effective width is pulse_width. A width of 0 selects TICKS_PER_SEC/10. A width of TICKS_PER_SEC or more is clamped to TICKS_PER_SEC-1, so the pulse is always shorter than a second.
- R10: After arm is sampled, fire is high for exactly one cycle. That cycle starts one clock after {now_sec,now_sub}, compared as one unsigned number, first reaches or passes {tgt_sec,tgt_sub}. It fires at most once per arm.
- R11: If the target is already at or behind local time when armed, fire is high in the second cycle after arm is sampled.
- R12: Arming while a trigger is pending replaces the pending target. The old target then never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, TICKS_PER_SEC cycles per nominal second |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous once-per-second reference pulse |
| sec_load_en | input | 1 | Load strobe for the seconds count |
| sec_load_val | input | SEC_W | Seconds value to load |
| arm | input | 1 | Captures the target and arms the trigger |
| tgt_sec | input | SEC_W | Target seconds |
| tgt_sub | input | SUB_W | Target subsecond ticks |
| pulse_width | input | SUB_W | Regenerated pulse width in ticks (0 selects default) |
| now_sec | output | SEC_W | Current seconds |
| now_sub | output | SUB_W | Current subsecond ticks |
| fire | output | 1 | One-cycle trigger pulse |
| locked | output | 1 | Reference pulse is present and in phase |
| phase_err | output | 1 | One-cycle flag for an out-of-window reference edge |
| pps_out | output | 1 | Regenerated once-per-second pulse |

## Verification
The assertions take for granted that TOLERANCE is less than half a second. Under that condition the early and late windows cannot overlap. They also assume that each reference pulse stays high for more than the synchronizer depth and that consecutive pulses are separated by a low phase, so each pulse yields exactly one snap. The stimulus keeps pps_in high for 20 cycles and spaces rising edges at least 97 cycles apart. Loads and arms are single-cycle strobes issued at subsecond values that the bench has chosen beforehand, so every expected time stays predictable.

// File: rtl/ppsd_pkg.sv
package ppsd_pkg;

    typedef int unsigned u32_t;

    // Where a reference edge landed relative to the expected rollover
    typedef enum logic [1:0] {
        PH_ALIGNED = 2'd0,   // at or slightly before the natural wrap
        PH_LATE_OK = 2'd1,   // just after the wrap, second already counted
        PH_OFF     = 2'd2    // outside both windows
    } phase_e;

    typedef struct packed {
        logic   hit;
        phase_e ph;
    } pps_evt_t;

    function automatic phase_e phase_class(u32_t sub, u32_t ticks, u32_t tol);
        if (sub < tol)
            return PH_LATE_OK;
        else if (sub >= ticks - 1 - tol)
            return PH_ALIGNED;
        else
            return PH_OFF;
    endfunction

    function automatic u32_t eff_width(u32_t w, u32_t ticks);
        if (w == 0)
            return ticks / 10;
        else if (w >= ticks)
            return ticks - 1;
        else
            return w;
    endfunction

endpackage

// File: rtl/ppsd_sync.sv
module ppsd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sh[STAGES-1];
    end

    assign rise = sh[STAGES-1] & ~prev;

    a_r3_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/ppsd_counter.sv
module ppsd_counter
    import ppsd_pkg::*;
#(
    parameter int unsigned TICKS = 100,
    parameter int unsigned SEC_W = 16,
    parameter int unsigned SUB_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  pps_evt_t         evt,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_val,
    output logic [SEC_W-1:0] sec,
    output logic [SUB_W-1:0] sub
);
    localparam logic [SUB_W-1:0] LAST = SUB_W'(TICKS - 1);

    logic wrap;
    logic bump;

    assign wrap = (sub == LAST);
    assign bump = evt.hit ? (evt.ph != PH_LATE_OK) : wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub <= '0;
            sec <= '0;
        end else begin
            if (evt.hit || wrap) sub <= '0;
            else                 sub <= sub + 1'b1;

            if (load_en)   sec <= load_val;
            else if (bump) sec <= sec + 1'b1;
        end
    end

    a_r2_sub_range: assert property (@(posedge clk) disable iff (rst)
        sub <= LAST);

    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> sec == $past(load_val));

    a_r2_wrap_step: assert property (@(posedge clk) disable iff (rst)
        (wrap && !load_en) |=> sec == $past(sec) + 1'b1);

endmodule

// File: rtl/ppsd_lock.sv
module ppsd_lock
    import ppsd_pkg::*;
#(
    parameter int unsigned TICKS = 100,
    parameter int unsigned TOL   = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  pps_evt_t evt,
    output logic     locked,
    output logic     phase_err
);
    localparam int unsigned LIMIT = TICKS + TOL;
    localparam int unsigned GAP_W = $clog2(LIMIT + 1);
    localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(LIMIT);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(LIMIT - 1);

    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= '0;
            locked    <= 1'b0;
            phase_err <= 1'b0;
        end else begin
            phase_err <= evt.hit && (evt.ph == PH_OFF);
            if (evt.hit) begin
                gap    <= '0;
                locked <= (evt.ph != PH_OFF);
            end else begin
                if (gap != GAP_MAX) gap <= gap + 1'b1;
                if (gap == GAP_LAST) locked <= 1'b0;
            end
        end
    end

    a_r6_lock_needs_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(evt.hit));

    a_r5_err_unlocks: assert property (@(posedge clk) disable iff (rst)
        phase_err |-> !locked);

    a_r7_gap_bound: assert property (@(posedge clk) disable iff (rst)
        locked |-> gap < GAP_MAX);

endmodule

// File: rtl/ppsd_trigger.sv
module ppsd_trigger #(
    parameter int unsigned SEC_W = 16,
    parameter int unsigned SUB_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [SUB_W-1:0] tgt_sub,
    input  logic [SEC_W-1:0] sec,
    input  logic [SUB_W-1:0] sub,
    output logic             fire
);
    logic [SEC_W+SUB_W-1:0] tgt_q;
    logic                   pending;
    logic                   reached;

    assign reached = {sec, sub} >= tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q   <= '0;
            pending <= 1'b0;
            fire    <= 1'b0;
        end else begin
            fire <= pending && reached;
            if (arm) begin
                tgt_q   <= {tgt_sec, tgt_sub};
                pending <= 1'b1;
            end else if (reached) begin
                pending <= 1'b0;
            end
        end
    end

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    a_r10_disarms: assert property (@(posedge clk) disable iff (rst)
        fire |-> (!pending || $past(arm)));

endmodule

// File: rtl/ppsd_timebase.sv
module ppsd_timebase
    import ppsd_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 50_000_000,
    parameter int unsigned TOLERANCE     = 1000,
    parameter int unsigned SEC_W         = 32,
    parameter int unsigned SYNC_STAGES   = 2,
    localparam int unsigned SUB_W        = $clog2(TICKS_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pps_in,
    input  logic             sec_load_en,
    input  logic [SEC_W-1:0] sec_load_val,
    input  logic             arm,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [SUB_W-1:0] tgt_sub,
    input  logic [SUB_W-1:0] pulse_width,
    output logic [SEC_W-1:0] now_sec,
    output logic [SUB_W-1:0] now_sub,
    output logic             fire,
    output logic             locked,
    output logic             phase_err,
    output logic             pps_out
);
    localparam logic [SUB_W-1:0] LAST = SUB_W'(TICKS_PER_SEC - 1);

    logic     rise;
    pps_evt_t evt;

    ppsd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pps_in),
        .rise (rise)
    );

    always_comb begin
        evt.hit = rise;
        evt.ph  = phase_class(u32_t'(now_sub), TICKS_PER_SEC, TOLERANCE);
    end

    ppsd_counter #(.TICKS(TICKS_PER_SEC), .SEC_W(SEC_W), .SUB_W(SUB_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .load_en  (sec_load_en),
        .load_val (sec_load_val),
        .sec      (now_sec),
        .sub      (now_sub)
    );

    ppsd_lock #(.TICKS(TICKS_PER_SEC), .TOL(TOLERANCE)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .locked    (locked),
        .phase_err (phase_err)
    );

    ppsd_trigger #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_trig (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .tgt_sec (tgt_sec),
        .tgt_sub (tgt_sub),
        .sec     (now_sec),
        .sub     (now_sub),
        .fire    (fire)
    );

    assign pps_out = u32_t'(now_sub) < eff_width(u32_t'(pulse_width), TICKS_PER_SEC);

    a_r3_snap_zero: assert property (@(posedge clk) disable iff (rst)
        rise |=> now_sub == '0);

    a_r9_low_before_wrap: assert property (@(posedge clk) disable iff (rst)
        (now_sub == LAST) |-> !pps_out);

    a_r9_high_at_start: assert property (@(posedge clk) disable iff (rst)
        (now_sub == '0) |-> pps_out);

endmodule

// File: tb/sim_ppsd_timebase.sv
`timescale 1ns/1ps
module sim_ppsd_timebase;

    localparam int T   = 100;
    localparam int TOL = 4;
    localparam int SW  = 16;
    localparam int BW  = $clog2(T);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pps_in = 1'b0;
    logic          sec_load_en = 1'b0;
    logic [SW-1:0] sec_load_val = '0;
    logic          arm = 1'b0;
    logic [SW-1:0] tgt_sec = '0;
    logic [BW-1:0] tgt_sub = '0;
    logic [BW-1:0] pulse_width = '0;
    logic [SW-1:0] now_sec;
    logic [BW-1:0] now_sub;
    logic          fire, locked, phase_err, pps_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int rise_at = -1000;

    ppsd_timebase #(.TICKS_PER_SEC(T), .TOLERANCE(TOL), .SEC_W(SW)) u0 (
        .clk(clk), .rst(rst), .pps_in(pps_in),
        .sec_load_en(sec_load_en), .sec_load_val(sec_load_val),
        .arm(arm), .tgt_sec(tgt_sec), .tgt_sub(tgt_sub),
        .pulse_width(pulse_width),
        .now_sec(now_sec), .now_sub(now_sub), .fire(fire),
        .locked(locked), .phase_err(phase_err), .pps_out(pps_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // reference pulse: high for 20 cycles starting at negedge cyc == rise_at
    always @(negedge clk) pps_in <= (cyc >= rise_at) && (cyc < rise_at + 20);

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic to_cyc(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wait_sub(int v);
        step();
        while (int'(now_sub) != v) step();
    endtask

    always @(posedge clk) begin
        if (cyc > 60000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: got %0d cycles expected under 60000", cyc);
            report();
        end
    end

    initial begin
        int ps, pc, r1, r2, r3, r4, r5, r6, r7, r8, s0, ref0, sec_ref, s, nf, ones, ew, guard;

        // R1: reset state
        repeat (3) step();
        chk("R1 sec", int'(now_sec), 0);
        chk("R1 sub", int'(now_sub), 0);
        chk("R1 locked", int'(locked), 0);
        chk("R1 fire", int'(fire), 0);
        chk("R1 phase_err", int'(phase_err), 0);
        rst = 1'b0;
        step();
        chk("R1 first cycle sec", int'(now_sec), 0);
        chk("R1 first cycle sub", int'(now_sub), 1);

        // R2: free-running sweep across several wraps
        ps = int'(now_sub);
        pc = int'(now_sec);
        for (int i = 0; i < 250; i++) begin
            step();
            chk("R2 sub step", int'(now_sub), (ps + 1) % T);
            chk("R2 sec step", int'(now_sec), pc + ((ps == T - 1) ? 1 : 0));
            ps = int'(now_sub);
            pc = int'(now_sec);
        end
        chk("R6 not locked without edges", int'(locked), 0);

        // first edge lands mid-second: R3, R4, R5
        wait_sub(45);
        r1 = cyc + 2;
        rise_at = r1;
        to_cyc(r1 + 2);
        chk("R3 pre-snap sub", int'(now_sub), 49);
        s0 = int'(now_sec);
        to_cyc(r1 + 3);
        chk("R3 snapped sub", int'(now_sub), 0);
        chk("R4 sec on snap", int'(now_sec), s0 + 1);
        chk("R5 phase_err pulse", int'(phase_err), 1);
        chk("R5 not locked", int'(locked), 0);
        to_cyc(r1 + 4);
        chk("R5 phase_err one cycle", int'(phase_err), 0);
        chk("R3 counting after snap", int'(now_sub), 1);

        // aligned edge: R6
        r2 = r1 + 100;
        rise_at = r2;
        to_cyc(r2 + 2);
        chk("R6 pre-snap sub", int'(now_sub), T - 1);
        s0 = int'(now_sec);
        to_cyc(r2 + 3);
        chk("R6 snapped sub", int'(now_sub), 0);
        chk("R4 sec aligned", int'(now_sec), s0 + 1);
        chk("R6 locked", int'(locked), 1);
        chk("R5 no phase_err aligned", int'(phase_err), 0);

        // locked sweep with aligned edges; pps_out at default width (R9)
        ref0 = r2 + 3;
        sec_ref = s0 + 1;
        r3 = r2 + 100;
        r4 = r2 + 200;
        rise_at = r3;
        while (cyc < ref0 + 299) begin
            step();
            if (cyc == r3 + 25) rise_at = r4;
            chk("R2 sub locked sweep", int'(now_sub), (cyc - ref0) % T);
            chk("R2 sec locked sweep", int'(now_sec), sec_ref + (cyc - ref0) / T);
            chk("R6 stays locked", int'(locked), 1);
            chk("R9 default width", int'(pps_out), (((cyc - ref0) % T) < T / 10) ? 1 : 0);
        end

        // late edge inside tolerance: R4 no double count
        r5 = r4 + 103;
        rise_at = r5;
        to_cyc(r5 + 2);
        chk("R4 late pre-snap sub", int'(now_sub), 2);
        s0 = int'(now_sec);
        to_cyc(r5 + 3);
        chk("R4 late snap sub", int'(now_sub), 0);
        chk("R4 late sec unchanged", int'(now_sec), s0);
        chk("R6 late keeps lock", int'(locked), 1);
        chk("R5 late no error", int'(phase_err), 0);

        // early edge inside tolerance
        r6 = r5 + 97;
        rise_at = r6;
        to_cyc(r6 + 2);
        chk("R4 early pre-snap sub", int'(now_sub), 96);
        s0 = int'(now_sec);
        to_cyc(r6 + 3);
        chk("R4 early sec", int'(now_sec), s0 + 1);
        chk("R5 early no error", int'(phase_err), 0);
        chk("R6 early keeps lock", int'(locked), 1);

        // late by exactly TOLERANCE: boundary, out of window
        r7 = r6 + 105;
        rise_at = r7;
        to_cyc(r7 + 2);
        chk("R5 boundary pre-snap sub", int'(now_sub), TOL);
        s0 = int'(now_sec);
        to_cyc(r7 + 3);
        chk("R4 boundary sec", int'(now_sec), s0 + 1);
        chk("R5 boundary phase_err", int'(phase_err), 1);
        chk("R5 boundary unlock", int'(locked), 0);

        // relock, then lose the reference: R7
        r8 = r7 + 100;
        rise_at = r8;
        to_cyc(r8 + 3);
        chk("R6 relock", int'(locked), 1);
        to_cyc(r8 + 3 + T + TOL - 1);
        chk("R7 still locked at limit-1", int'(locked), 1);
        to_cyc(r8 + 3 + T + TOL);
        chk("R7 unlocked at limit", int'(locked), 0);
        to_cyc(r8 + 3 + 150);
        chk("R7 free-run continues", int'(now_sub), 50);

        // R8: seconds load, plain and on a wrap
        wait_sub(30);
        sec_load_en = 1'b1;
        sec_load_val = 16'd1000;
        step();
        sec_load_en = 1'b0;
        chk("R8 load sec", int'(now_sec), 1000);
        chk("R8 load sub untouched", int'(now_sub), 31);
        wait_sub(T - 1);
        sec_load_en = 1'b1;
        sec_load_val = 16'd2000;
        step();
        sec_load_en = 1'b0;
        chk("R8 load beats wrap", int'(now_sec), 2000);
        chk("R8 wrap sub", int'(now_sub), 0);
        to_cyc(cyc + T);
        chk("R8 next wrap", int'(now_sec), 2001);

        // R9: width sweep including default and clamp
        for (int k = 0; k < 4; k++) begin
            int w;
            w = (k == 0) ? 25 : (k == 1) ? 120 : (k == 2) ? 0 : 1;
            ew = (w == 0) ? T / 10 : (w >= T) ? T - 1 : w;
            wait_sub(50);
            pulse_width = BW'(w);
            wait_sub(0);
            ones = 0;
            for (int i = 0; i < T; i++) begin
                chk("R9 pps_out level", int'(pps_out), (int'(now_sub) < ew) ? 1 : 0);
                if (pps_out) ones++;
                step();
            end
            chk("R9 high cycles per second", ones, ew);
        end

        // R10: future target
        wait_sub(10);
        s = int'(now_sec);
        tgt_sec = SW'(s + 1);
        tgt_sub = BW'(37);
        arm = 1'b1;
        step();
        arm = 1'b0;
        nf = 0;
        guard = 0;
        while (!(int'(now_sec) == s + 1 && int'(now_sub) == 37) && guard < 400) begin
            if (fire) nf++;
            step();
            guard++;
        end
        chk("R10 no early fire", nf, 0);
        chk("R10 low when reached", int'(fire), 0);
        step();
        chk("R10 fires next cycle", int'(fire), 1);
        nf = 0;
        for (int i = 0; i < 150; i++) begin
            step();
            if (fire) nf++;
        end
        chk("R10 once per arm", nf, 0);

        // R11: target already past
        tgt_sec = '0;
        tgt_sub = '0;
        arm = 1'b1;
        step();
        arm = 1'b0;
        chk("R11 not yet", int'(fire), 0);
        step();
        chk("R11 immediate fire", int'(fire), 1);
        step();
        chk("R11 single cycle", int'(fire), 0);

        // R12: re-arm replaces pending target
        wait_sub(10);
        s = int'(now_sec);
        tgt_sec = SW'(s + 3);
        tgt_sub = BW'(50);
        arm = 1'b1;
        step();
        arm = 1'b0;
        step();
        tgt_sec = SW'(s + 1);
        tgt_sub = BW'(20);
        arm = 1'b1;
        step();
        arm = 1'b0;
        guard = 0;
        while (!(int'(now_sec) == s + 1 && int'(now_sub) == 20) && guard < 400) begin
            step();
            guard++;
        end
        step();
        chk("R12 new target fires", int'(fire), 1);
        nf = 0;
        guard = 0;
        while (!(int'(now_sec) == s + 3 && int'(now_sub) == 60) && guard < 400) begin
            step();
            if (fire) nf++;
            guard++;
        end
        chk("R12 old target dropped", nf, 0);

        report();
    end

endmodule